// File: doc/BRIEF.md
# Capture/Reload Timer Pair

This block is a 16-bit up/down counter with a toggle flag, plus two 16-bit helper registers. The counter advances by one on each cycle where the count strobe is high. The direction comes from a control input. The toggle flag inverts each time the counter wraps past its top or bottom value.

Each helper register has a mode. It can sit idle, or capture the counter value when its own pin shows an edge. It can also reload the counter. A reload fires on a pin edge when that trigger is enabled, or on a chosen transition of the toggle flag.

Waveform generation uses both helpers in reload mode. One reloads on the flag's rising transition and the other on its falling transition. The flag output is then a continuous pulse train. Its high and low times are set by the two stored values, and no further writes are needed.

Top module: `ptmr_top`

## Requirements
- R1: After synchronous reset the counter reads 0, the toggle flag reads 0 and both helper registers read 0.
- R2: On a cycle with `cnt_en` high and no write or reload, the counter steps by one: down when `dir_down` is 1, up when it is 0. With `cnt_en` low and no write or reload, it holds.
- R3: The toggle flag inverts on a count step that wraps, either 0xFFFF to 0x0000 counting up or 0x0000 to 0xFFFF counting down. It changes at no other time.
- R4: A counter write (`core_wr`) loads `core_wdata` at the next edge. It overrides any reload and any count step in that cycle. In that cycle the toggle flag does not change.
- R5: A helper write (`aux_wr[i]`) loads slice i of `aux_wdata` at the next edge. Slice i is bits 16*i+15 down to 16*i.
- R6: Each helper has a 2-bit mode field in `aux_mode`: 00 idle, 01 capture, 10 reload, 11 idle. In capture mode, an edge on its pin copies the counter value into the helper. The edge kinds are chosen by the 2-bit `aux_pin_sel` field: 00 none, 01 rising, 10 falling, 11 both. The pin passes through two synchronizer flops, so the copy appears after the third rising clock edge that follows the pin change.
- R7: A helper in reload mode watches the toggle flag, using its 2-bit `aux_tgl_sel` field: 00 none, 01 flag rising, 10 flag falling, 11 either. When the selected transition occurs, the helper value replaces the wrapping count step at that same edge. The flag still inverts.
- R8: A helper in reload mode with its `aux_pin_rl_en` bit set also reloads the counter on a pin edge matching its `aux_pin_sel` field. The latency is the same three edges as in R6.
- R9: When both helpers request a reload in the same cycle, helper 0 supplies the value.
- R10: Set both helpers to reload mode, helper 0 on flag rising with value H and helper 1 on flag falling with value L, counting up. The flag then repeats with 0x10000-H cycles high and 0x10000-L cycles low.
- R11: A helper that is not in capture mode keeps its value through pin edges and reloads. It changes only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count strobe |
| dir_down | input | 1 | 1 counts down, 0 counts up |
| core_wr | input | 1 | Counter write strobe |
| core_wdata | input | 16 | Counter write value |
| aux_wr | input | 2 | Helper write strobes, one per helper |
| aux_wdata | input | 32 | Helper write values, helper i in bits 16*i+15:16*i |
| aux_mode | input | 4 | Helper modes, 2 bits each |
| aux_pin_sel | input | 4 | Pin edge selects, 2 bits each |
| aux_tgl_sel | input | 4 | Flag transition selects, 2 bits each |
| aux_pin_rl_en | input | 2 | Pin-triggered reload enables |
| aux_pin | input | 2 | Asynchronous helper pins |
| core_cnt | output | 16 | Counter value |
| tgl_out | output | 1 | Toggle flag |
| aux_val | output | 32 | Helper register values |

## Verification
Counter writes, count steps, flag inversions and flag-triggered reloads all settle after one rising edge. Pin-driven captures and reloads need three rising edges after the pin moves. The bench drives and samples on the falling edge and counts the exact number of rising edges before each comparison. For pin events it also checks the old value one edge before the deadline, so a design that reacts too early fails just as one that reacts too late does. The waveform test counts flag-high samples and flag rises over a whole number of periods, which checks the period and the duty cycle together.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int unsigned AUX_COUNT = 2;

    typedef enum logic [1:0] {
        AUX_IDLE    = 2'b00,
        AUX_CAPTURE = 2'b01,
        AUX_RELOAD  = 2'b10,
        AUX_SPARE   = 2'b11
    } aux_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_match(input logic [1:0] sel, input edge_ev_t ev);
        case (edge_sel_e'(sel))
            SEL_RISE: return ev.rise;
            SEL_FALL: return ev.fall;
            SEL_BOTH: return ev.rise | ev.fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_pin_sync.sv
module ptmr_pin_sync
    import ptmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output edge_ev_t ev
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    always_comb begin
        ev.rise = sync_q & ~last_q;
        ev.fall = ~sync_q & last_q;
    end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         dir_down,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         reload_fire,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         tgl,
    output edge_ev_t     tgl_ev
);
    localparam logic [W-1:0] CNT_TOP = '1;
    localparam logic [W-1:0] CNT_BOT = '0;
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, step_val;
    logic         tgl_q, wrap_ev;

    always_comb begin
        step_val = dir_down ? (cnt_q - ONE) : (cnt_q + ONE);
        wrap_ev  = cnt_en & ~wr & (dir_down ? (cnt_q == CNT_BOT) : (cnt_q == CNT_TOP));
        tgl_ev.rise = wrap_ev & ~tgl_q;
        tgl_ev.fall = wrap_ev & tgl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else begin
            if (wr)               cnt_q <= wdata;
            else if (reload_fire) cnt_q <= reload_val;
            else if (cnt_en)      cnt_q <= step_val;
            if (wrap_ev)          tgl_q <= ~tgl_q;
        end
    end

    assign cnt = cnt_q;
    assign tgl = tgl_q;
endmodule

// File: rtl/ptmr_aux.sv
module ptmr_aux
    import ptmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic [1:0]   pin_sel,
    input  logic [1:0]   tgl_sel,
    input  logic         pin_rl_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  edge_ev_t     pin_ev,
    input  edge_ev_t     tgl_ev,
    input  logic [W-1:0] core_cnt,
    output logic [W-1:0] val,
    output logic         reload_req
);
    logic [W-1:0] val_q;
    logic         pin_hit, grab;

    always_comb begin
        pin_hit    = edge_match(pin_sel, pin_ev);
        grab       = (aux_mode_e'(mode) == AUX_CAPTURE) && pin_hit;
        reload_req = (aux_mode_e'(mode) == AUX_RELOAD) &&
                     ((pin_rl_en && pin_hit) || edge_match(tgl_sel, tgl_ev));
    end

    always_ff @(posedge clk) begin
        if (rst)       val_q <= '0;
        else if (wr)   val_q <= wdata;
        else if (grab) val_q <= core_cnt;
    end

    assign val = val_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_en,
    input  logic                 dir_down,
    input  logic                 core_wr,
    input  logic [W-1:0]         core_wdata,
    input  logic [1:0]           aux_wr,
    input  logic [2*W-1:0]       aux_wdata,
    input  logic [3:0]           aux_mode,
    input  logic [3:0]           aux_pin_sel,
    input  logic [3:0]           aux_tgl_sel,
    input  logic [1:0]           aux_pin_rl_en,
    input  logic [1:0]           aux_pin,
    output logic [W-1:0]         core_cnt,
    output logic                 tgl_out,
    output logic [2*W-1:0]       aux_val
);
    edge_ev_t               tgl_ev;
    edge_ev_t               pin_ev     [AUX_COUNT];
    logic [W-1:0]           aux_q      [AUX_COUNT];
    logic [AUX_COUNT-1:0]   reload_req;
    logic                   reload_fire;
    logic [W-1:0]           reload_val;

    ptmr_core #(.W(W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .cnt_en      (cnt_en),
        .dir_down    (dir_down),
        .wr          (core_wr),
        .wdata       (core_wdata),
        .reload_fire (reload_fire),
        .reload_val  (reload_val),
        .cnt         (core_cnt),
        .tgl         (tgl_out),
        .tgl_ev      (tgl_ev)
    );

    for (genvar g = 0; g < AUX_COUNT; g++) begin : g_aux
        ptmr_pin_sync u_sync (
            .clk (clk),
            .rst (rst),
            .pin (aux_pin[g]),
            .ev  (pin_ev[g])
        );

        ptmr_aux #(.W(W)) u_aux (
            .clk        (clk),
            .rst        (rst),
            .mode       (aux_mode[2*g +: 2]),
            .pin_sel    (aux_pin_sel[2*g +: 2]),
            .tgl_sel    (aux_tgl_sel[2*g +: 2]),
            .pin_rl_en  (aux_pin_rl_en[g]),
            .wr         (aux_wr[g]),
            .wdata      (aux_wdata[W*g +: W]),
            .pin_ev     (pin_ev[g]),
            .tgl_ev     (tgl_ev),
            .core_cnt   (core_cnt),
            .val        (aux_q[g]),
            .reload_req (reload_req[g])
        );

        assign aux_val[W*g +: W] = aux_q[g];
    end

    // lowest index wins when several helpers request together
    always_comb begin
        reload_fire = 1'b0;
        reload_val  = '0;
        for (int i = AUX_COUNT - 1; i >= 0; i--) begin
            if (reload_req[i]) begin
                reload_fire = 1'b1;
                reload_val  = aux_q[i];
            end
        end
    end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int unsigned W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           cnt_en,
    input logic           dir_down,
    input logic           core_wr,
    input logic [W-1:0]   core_wdata,
    input logic           reload_fire,
    input logic [W-1:0]   core_cnt,
    input logic           tgl_out,
    input logic [3:0]     aux_mode,
    input logic [1:0]     aux_wr,
    input logic [2*W-1:0] aux_val
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !core_wr && !reload_fire) |=> $stable(core_cnt));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_down && !core_wr && !reload_fire) |=> (core_cnt == $past(core_cnt) + ONE));

    // R3
    wrap_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_down && !core_wr && core_cnt == TOP) |=> (tgl_out != $past(tgl_out)));

    // R4
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        core_wr |=> (core_cnt == $past(core_wdata)));

    // R4
    write_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        core_wr |=> $stable(tgl_out));

    // R11
    aux0_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!aux_wr[0] && aux_mode[1:0] != 2'b01) |=> $stable(aux_val[W-1:0]));

    // R11
    aux1_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!aux_wr[1] && aux_mode[3:2] != 2'b01) |=> $stable(aux_val[2*W-1:W]));
endmodule

bind ptmr_top ptmr_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_en      (cnt_en),
    .dir_down    (dir_down),
    .core_wr     (core_wr),
    .core_wdata  (core_wdata),
    .reload_fire (reload_fire),
    .core_cnt    (core_cnt),
    .tgl_out     (tgl_out),
    .aux_mode    (aux_mode),
    .aux_wr      (aux_wr),
    .aux_val     (aux_val)
);

// File: tb/ptmr_top_tb.sv
module ptmr_top_tb;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic           cnt_en, dir_down, core_wr;
    logic [W-1:0]   core_wdata;
    logic [1:0]     aux_wr, aux_pin_rl_en, aux_pin;
    logic [2*W-1:0] aux_wdata;
    logic [3:0]     aux_mode, aux_pin_sel, aux_tgl_sel;
    logic [W-1:0]   core_cnt;
    logic           tgl_out;
    logic [2*W-1:0] aux_val;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ptmr_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_down(dir_down),
        .core_wr(core_wr), .core_wdata(core_wdata), .aux_wr(aux_wr),
        .aux_wdata(aux_wdata), .aux_mode(aux_mode), .aux_pin_sel(aux_pin_sel),
        .aux_tgl_sel(aux_tgl_sel), .aux_pin_rl_en(aux_pin_rl_en), .aux_pin(aux_pin),
        .core_cnt(core_cnt), .tgl_out(tgl_out), .aux_val(aux_val)
    );

    // {dir_down, start, steps, expected count, expected flag flip}
    localparam logic [41:0] VECS [0:4] = '{
        {1'b0, 16'h0010, 8'd5, 16'h0015, 1'b0},
        {1'b0, 16'hFFFE, 8'd3, 16'h0001, 1'b1},
        {1'b1, 16'h0002, 8'd4, 16'hFFFE, 1'b1},
        {1'b1, 16'h8000, 8'd1, 16'h7FFF, 1'b0},
        {1'b0, 16'hFFFF, 8'd1, 16'h0000, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_core(input logic [W-1:0] v);
        core_wr = 1'b1;
        core_wdata = v;
        tick();
        core_wr = 1'b0;
    endtask

    task automatic wr_aux(input int i, input logic [W-1:0] v);
        aux_wr = '0;
        aux_wr[i] = 1'b1;
        aux_wdata[W*i +: W] = v;
        tick();
        aux_wr = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic t0;
        int highs, rises;
        logic prev;
        rst = 1'b1; cnt_en = 1'b0; dir_down = 1'b0; core_wr = 1'b0; core_wdata = '0;
        aux_wr = '0; aux_wdata = '0; aux_mode = '0; aux_pin_sel = '0;
        aux_tgl_sel = '0; aux_pin_rl_en = '0; aux_pin = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 count", core_cnt, '0);
        check("R1 flag", {15'd0, tgl_out}, 16'd0);
        check("R1 aux0", aux_val[15:0], '0);
        check("R1 aux1", aux_val[31:16], '0);

        // R2 R3 vector walk
        for (int k = 0; k < 5; k++) begin
            dir_down = VECS[k][41];
            wr_core(VECS[k][40:25]);
            t0 = tgl_out;
            cnt_en = 1'b1;
            for (int s = 0; s < int'(VECS[k][24:17]); s++) tick();
            cnt_en = 1'b0;
            check("R2 vector count", core_cnt, VECS[k][16:1]);
            check("R3 vector flag", {15'd0, tgl_out}, {15'd0, t0 ^ VECS[k][0]});
        end

        // R2 hold with strobe low
        dir_down = 1'b0;
        wr_core(16'h0042);
        tick(); tick(); tick();
        check("R2 hold", core_cnt, 16'h0042);

        // R5 R7 flag-triggered reload replaces the wrap step
        wr_aux(0, 16'h00A0);
        check("R5 aux0 write", aux_val[15:0], 16'h00A0);
        aux_mode[1:0] = 2'b10; aux_tgl_sel[1:0] = 2'b11;
        wr_core(16'hFFFF);
        t0 = tgl_out;
        cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        check("R7 reload value", core_cnt, 16'h00A0);
        check("R7 flag flips", {15'd0, tgl_out}, {15'd0, ~t0});
        check("R11 aux0 kept", aux_val[15:0], 16'h00A0);

        // R9 both request, helper 0 wins
        wr_aux(1, 16'h0BBB);
        aux_mode[3:2] = 2'b10; aux_tgl_sel[3:2] = 2'b11;
        wr_core(16'hFFFF);
        cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        check("R9 priority", core_cnt, 16'h00A0);

        // R4 write beats reload and count, flag held
        wr_core(16'hFFFF);
        t0 = tgl_out;
        cnt_en = 1'b1; core_wr = 1'b1; core_wdata = 16'h1234;
        tick();
        cnt_en = 1'b0; core_wr = 1'b0;
        check("R4 write wins", core_cnt, 16'h1234);
        check("R4 flag held", {15'd0, tgl_out}, {15'd0, t0});

        // R6 capture on rising pin edge, three-edge latency
        aux_mode = 4'b0100; aux_tgl_sel = '0; aux_pin_sel = 4'b0100;
        wr_core(16'h4321);
        aux_pin[1] = 1'b1;
        tick(); tick();
        check("R6 not yet captured", aux_val[31:16], 16'h0BBB);
        tick();
        check("R6 captured", aux_val[31:16], 16'h4321);

        // R6 falling edge ignored under rising select, then both-edge select
        wr_core(16'h1111);
        aux_pin[1] = 1'b0;
        tick(); tick(); tick(); tick();
        check("R6 wrong edge ignored", aux_val[31:16], 16'h4321);
        aux_pin_sel[3:2] = 2'b11;
        aux_pin[1] = 1'b1;
        tick(); tick(); tick();
        check("R6 both edges", aux_val[31:16], 16'h1111);

        // R11 idle helper ignores pin edges
        aux_pin_sel[1:0] = 2'b11;
        aux_pin[0] = 1'b1;
        tick(); tick(); tick(); tick();
        check("R11 idle aux0", aux_val[15:0], 16'h00A0);
        aux_pin[0] = 1'b0;
        tick(); tick(); tick(); tick();

        // R8 pin-triggered reload
        aux_mode[1:0] = 2'b10; aux_pin_sel[1:0] = 2'b01; aux_pin_rl_en[0] = 1'b1;
        wr_aux(0, 16'h0777);
        wr_core(16'h0100);
        aux_pin[0] = 1'b1;
        tick(); tick();
        check("R8 not yet reloaded", core_cnt, 16'h0100);
        tick();
        check("R8 pin reload", core_cnt, 16'h0777);
        check("R11 reload source kept", aux_val[15:0], 16'h0777);

        // R10 continuous waveform: high 3, low 5
        aux_pin = '0;
        do_reset();
        aux_mode = 4'b1010; aux_pin_rl_en = '0; aux_pin_sel = '0;
        aux_tgl_sel = 4'b1001;
        wr_aux(0, 16'hFFFD);
        wr_aux(1, 16'hFFFB);
        dir_down = 1'b0;
        wr_core(16'hFFFB);
        highs = 0; rises = 0; prev = tgl_out;
        cnt_en = 1'b1;
        for (int c = 0; c < 64; c++) begin
            tick();
            if (tgl_out) highs++;
            if (tgl_out && !prev) rises++;
            prev = tgl_out;
        end
        cnt_en = 1'b0;
        check("R10 high cycles", 16'(highs), 16'd24);
        check("R10 periods", 16'(rises), 16'd8);
        check("R10 phase count", core_cnt, 16'hFFFB);
        check("R10 phase flag", {15'd0, tgl_out}, 16'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule